// File: doc/BRIEF.md
# Discriminator Hit Timestamp Collector

This block watches the discriminator outputs of a board's front-end chips during a beam acquisition. Each chip exposes one selectable half of its discriminator channels, normally the high-gain half. The block records a timestamp and a channel address for every rising edge it sees while either acquisition window is open. One window covers the spill itself. The other covers the period after the spill, which catches late signals.

Timestamps count cycles of the board clock, starting from zero at the spill-start pulse. Recorded hits are held in an on-chip buffer until both windows have closed. They are then streamed out over a ready/valid port, in time order, so that they can be appended to the digitised analogue data. The stream ends with one trailer word that carries the hit count and a flag showing whether any hit was lost.

Top module: `hts_collector`

## Requirements
- R1: Every discriminator input passes through two synchronising flops. A hit is a low-to-high change of the synchronised line, so a line held high for many cycles yields exactly one hit, and it yields another hit only after it has gone low and risen again.
- R2: `spill_start` clears the timestamp counter, and the counter then advances by one on every clock. A hit on a line that is first sampled high k clock edges after the edge that sampled `spill_start` carries timestamp k+1.
- R3: The timestamp counter stops at 2^TS_W-1 and holds that value until the next `spill_start`. It does not wrap.
- R4: A hit address has ADDR_W = log2(NUM_CHIPS)+1+log2(LINES) bits. The chip index is in the top bits. The next bit is that chip's `half_sel` bit, where 1 means the upper half of its channels. The line number within the chip's visible group is in the low log2(LINES) bits.
- R5: A rising edge is recorded only if `spill_win` or `late_win` is high in the cycle the synchronised edge appears. Edges outside both windows leave no word in the stream.
- R6: Hits detected in the same cycle share one timestamp and are queued in ascending address order. Hits from different cycles are queued in time order.
- R7: `out_valid` stays low while hits are being collected. Streaming begins only after both windows are low and every detected hit has been written to the buffer. A hit word has bit OUT_W-1 = 0, the timestamp in bits [TS_W+ADDR_W-1:ADDR_W] and the address in bits [ADDR_W-1:0].
- R8: When the hit buffer (DEPTH entries) is full, further hits are discarded and the overflow flag is set. The first DEPTH hits are kept.
- R9: The last word of each stream is a trailer. It has bit OUT_W-1 = 1, bit OUT_W-2 = overflow flag, the number of stored hits in the low log2(DEPTH+1) bits, and zeros elsewhere. Once the trailer is accepted, the count and the flag are cleared for the next spill, including for a spill that records no hits.
- R10: While `out_valid` is high and `out_ready` is low, `out_data` stays unchanged. Each accepted handshake moves exactly one word.
- R11: After reset, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Board clock; also the timestamp time base |
| rst_n | input | 1 | Active-low synchronous reset |
| spill_start | input | 1 | One-cycle pulse that zeroes the timestamp counter |
| spill_win | input | 1 | Spill acquisition window |
| late_win | input | 1 | Post-spill window for late signals |
| half_sel | input | NUM_CHIPS | Per chip: 1 means the visible lines are the upper channel half |
| disc | input | NUM_CHIPS*LINES | Discriminator lines; chip c owns lines c*LINES to c*LINES+LINES-1 |
| out_ready | input | 1 | Downstream can accept a word |
| out_valid | output | 1 | A stream word is presented |
| out_data | output | TS_W+ADDR_W+1 | Hit word or trailer word |

## Verification
The bench runs a small configuration with an 8-bit timestamp and an 8-entry buffer. It sweeps a single hit across every one of the 64 lines, with a different half-select pattern in each spill. This separates address-field mistakes by chip, by half and by line. Some spills hand over from the spill window to the late window partway through. One multi-line hit on lines spread over all four chips checks the ordering rule. A line held high, a hit placed after counter saturation, and a burst larger than the buffer separate edge detection, saturation and overflow behaviour. The stream is read with a ready line that stalls one cycle in three, and an empty spill confirms that the trailer count resets.

// File: rtl/hts_pkg.sv
package hts_pkg;

  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_DRAIN   = 2'd1,
    ST_TRAIL   = 2'd2
  } hts_state_e;

  // Saturating increment on a wide carrier; callers narrow the result.
  function automatic logic [31:0] sat_inc(input logic [31:0] cur, input logic [31:0] lim);
    return (cur >= lim) ? lim : cur + 32'd1;
  endfunction

endpackage

// File: rtl/hts_sync_edge.sv
module hts_sync_edge #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise
);

  for (genvar g = 0; g < N; g++) begin : g_lane
    logic [2:0] sh_q;

    always_ff @(posedge clk) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[1:0], din[g]};
    end

    // sh_q[1] is the second synchroniser flop; sh_q[2] is its delayed copy.
    assign rise[g] = sh_q[1] & ~sh_q[2];

    assert_single_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rise[g] |=> !rise[g]);
  end

endmodule

// File: rtl/hts_snap_queue.sv
module hts_snap_queue #(
  parameter int N    = 64,
  parameter int TS_W = 20,
  parameter int SNAP = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push,
  input  logic [N-1:0]         push_mask,
  input  logic [TS_W-1:0]      push_ts,
  output logic                 pick_valid,
  output logic [$clog2(N)-1:0] pick_idx,
  output logic [TS_W-1:0]      pick_ts,
  output logic                 empty,
  output logic                 drop
);

  localparam int IDX_W = $clog2(N);
  localparam int PTR_W = (SNAP > 1) ? $clog2(SNAP) : 1;
  localparam int CNT_W = $clog2(SNAP + 1);

  logic [N-1:0]     mask_q [SNAP];
  logic [TS_W-1:0]  ts_q   [SNAP];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;

  logic [N-1:0] head_mask, pick_bit, rest_mask;
  logic         full, push_ok, pop;

  function automatic logic [IDX_W-1:0] lowest_set(input logic [N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(SNAP - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty      = (cnt_q == '0);
  assign full       = (cnt_q == CNT_W'(SNAP));
  assign pick_valid = !empty;
  assign head_mask  = mask_q[rd_q];
  assign pick_idx   = lowest_set(head_mask);
  assign pick_ts    = ts_q[rd_q];
  assign pick_bit   = {{(N-1){1'b0}}, 1'b1} << pick_idx;
  assign rest_mask  = head_mask & ~pick_bit;
  assign pop        = pick_valid && (rest_mask == '0);
  assign push_ok    = push && !full;
  assign drop       = push && full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < SNAP; e++) begin
        mask_q[e] <= '0;
        ts_q[e]   <= '0;
      end
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (pick_valid) mask_q[rd_q] <= rest_mask;
      if (push_ok) begin
        mask_q[wr_q] <= push_mask;
        ts_q[wr_q]   <= push_ts;
        wr_q         <= bump(wr_q);
      end
      if (pop) rd_q <= bump(rd_q);
      cnt_q <= cnt_q + CNT_W'(push_ok) - CNT_W'(pop);
    end
  end

  // A queued snapshot always has at least one line left to hand out.
  assert_head_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> (head_mask != '0));

endmodule

// File: rtl/hts_hit_fifo.sv
module hts_hit_fifo #(
  parameter int W     = 27,
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= bump(wr_q);
      if (do_pop)  rd_q <= bump(rd_q);
      cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/hts_collector.sv
module hts_collector
  import hts_pkg::*;
#(
  parameter int NUM_CHIPS = 4,
  parameter int LINES     = 16,
  parameter int TS_W      = 20,
  parameter int DEPTH     = 64,
  parameter int SNAP      = 4
) (
  input  logic                                              clk,
  input  logic                                              rst_n,
  input  logic                                              spill_start,
  input  logic                                              spill_win,
  input  logic                                              late_win,
  input  logic [NUM_CHIPS-1:0]                              half_sel,
  input  logic [NUM_CHIPS*LINES-1:0]                        disc,
  input  logic                                              out_ready,
  output logic                                              out_valid,
  output logic [TS_W+$clog2(NUM_CHIPS)+$clog2(LINES)+1:0]   out_data
);

  localparam int N      = NUM_CHIPS * LINES;
  localparam int CHIP_W = $clog2(NUM_CHIPS);
  localparam int LINE_W = $clog2(LINES);
  localparam int IDX_W  = $clog2(N);
  localparam int ADDR_W = CHIP_W + 1 + LINE_W;
  localparam int HIT_W  = TS_W + ADDR_W;
  localparam int OUT_W  = HIT_W + 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam logic [TS_W-1:0] TS_MAX = '1;

  // Named internal events used by the assertions below.
  logic [N-1:0]      rise;
  logic              acq_open, record;
  logic              pick_valid, snap_empty, snap_drop;
  logic [IDX_W-1:0]  pick_idx;
  logic [TS_W-1:0]   pick_ts;
  logic              fifo_full, fifo_empty, fifo_pop;
  logic [HIT_W-1:0]  fifo_dout;
  logic              hit_keep, hit_drop, trail_fire;

  hts_state_e        state_q;
  logic [TS_W-1:0]   ts_q;
  logic [CNT_W-1:0]  rec_cnt_q;
  logic              ovf_q, seen_q;

  function automatic logic [ADDR_W-1:0] mk_addr(input logic [IDX_W-1:0] idx,
                                                input logic [NUM_CHIPS-1:0] hs);
    logic [CHIP_W-1:0] chip;
    chip = idx[IDX_W-1:LINE_W];
    return {chip, hs[chip], idx[LINE_W-1:0]};
  endfunction

  function automatic logic [OUT_W-1:0] mk_trailer(input logic ovf, input logic [CNT_W-1:0] cnt);
    logic [OUT_W-1:0] w;
    w                = '0;
    w[OUT_W-1]       = 1'b1;
    w[OUT_W-2]       = ovf;
    w[CNT_W-1:0]     = cnt;
    return w;
  endfunction

  hts_sync_edge #(.N(N)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (disc),
    .rise (rise)
  );

  assign acq_open = spill_win | late_win;
  assign record   = (state_q == ST_COLLECT) && acq_open && (rise != '0);

  hts_snap_queue #(.N(N), .TS_W(TS_W), .SNAP(SNAP)) u_snap (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (record),
    .push_mask (rise),
    .push_ts   (ts_q),
    .pick_valid(pick_valid),
    .pick_idx  (pick_idx),
    .pick_ts   (pick_ts),
    .empty     (snap_empty),
    .drop      (snap_drop)
  );

  assign hit_keep = pick_valid && !fifo_full;
  assign hit_drop = pick_valid && fifo_full;

  hts_hit_fifo #(.W(HIT_W), .DEPTH(DEPTH)) u_fifo (
    .clk  (clk),
    .rst_n(rst_n),
    .push (pick_valid),
    .din  ({pick_ts, mk_addr(pick_idx, half_sel)}),
    .pop  (fifo_pop),
    .dout (fifo_dout),
    .full (fifo_full),
    .empty(fifo_empty)
  );

  assign out_valid  = ((state_q == ST_DRAIN) && !fifo_empty) || (state_q == ST_TRAIL);
  assign out_data   = (state_q == ST_TRAIL) ? mk_trailer(ovf_q, rec_cnt_q) : {1'b0, fifo_dout};
  assign fifo_pop   = (state_q == ST_DRAIN) && !fifo_empty && out_ready;
  assign trail_fire = (state_q == ST_TRAIL) && out_ready;

  // Timestamp base
  always_ff @(posedge clk) begin
    if (!rst_n)           ts_q <= '0;
    else if (spill_start) ts_q <= '0;
    else                  ts_q <= TS_W'(sat_inc(32'(ts_q), 32'(TS_MAX)));
  end

  // Sequencing, count and loss flag
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_COLLECT;
      rec_cnt_q <= '0;
      ovf_q     <= 1'b0;
      seen_q    <= 1'b0;
    end else begin
      if (hit_keep)               rec_cnt_q <= rec_cnt_q + 1'b1;
      if (hit_drop || snap_drop)  ovf_q     <= 1'b1;
      unique case (state_q)
        ST_COLLECT: begin
          if (acq_open) seen_q <= 1'b1;
          if (!acq_open && seen_q && snap_empty) state_q <= ST_DRAIN;
        end
        ST_DRAIN: begin
          if (fifo_empty) state_q <= ST_TRAIL;
        end
        ST_TRAIL: begin
          if (trail_fire) begin
            state_q   <= ST_COLLECT;
            seen_q    <= 1'b0;
            rec_cnt_q <= '0;
            ovf_q     <= 1'b0;
          end
        end
        default: state_q <= ST_COLLECT;
      endcase
    end
  end

  assert_ts_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    spill_start |=> (ts_q == '0));

  assert_ts_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_q == TS_MAX && !spill_start) |=> (ts_q == TS_MAX));

  assert_drop_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_drop || snap_drop) |=> ovf_q);

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_trailer_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TRAIL) |-> fifo_empty);

  assert_no_early_stream_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_open && state_q == ST_COLLECT) |=> !out_valid || !$past(state_q == ST_COLLECT) || $past(!acq_open));

endmodule

// File: tb/test_hts_collector.sv
module test_hts_collector;

  localparam int NC    = 4;
  localparam int NL    = 16;
  localparam int TSW   = 8;
  localparam int DEP   = 8;
  localparam int NLINE = NC * NL;
  localparam int TSMAX = (1 << TSW) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             spill_start = 1'b0;
  logic             spill_win = 1'b0;
  logic             late_win = 1'b0;
  logic             out_ready = 1'b0;
  logic [NC-1:0]    half_sel = '0;
  logic [NLINE-1:0] disc = '0;
  logic             out_valid;
  logic [15:0]      out_data;

  int  tests = 0;
  int  fails = 0;
  bit  finished = 0;
  int  edge_cnt = 0;
  logic [15:0] exp_q [64];
  int  exp_n = 0;
  bit  exp_ovf = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (spill_start) edge_cnt <= 0;
    else             edge_cnt <= edge_cnt + 1;
  end

  hts_collector #(.NUM_CHIPS(NC), .LINES(NL), .TS_W(TSW), .DEPTH(DEP), .SNAP(4)) i_hts_collector (
    .clk        (clk),
    .rst_n      (rst_n),
    .spill_start(spill_start),
    .spill_win  (spill_win),
    .late_win   (late_win),
    .half_sel   (half_sel),
    .disc       (disc),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_data   (out_data)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic begin_spill(input logic [NC-1:0] hs);
    half_sel    = hs;
    exp_n       = 0;
    exp_ovf     = 0;
    spill_start = 1'b1;
    spill_win   = 1'b1;
    @(negedge clk);
    spill_start = 1'b0;
  endtask

  // Raise the lines in m for 'hold' cycles; the expected words are computed first.
  task automatic fire(input logic [NLINE-1:0] m, input int hold);
    int ts;
    ts = edge_cnt + 2;
    if (ts > TSMAX) ts = TSMAX;
    for (int i = 0; i < NLINE; i++) begin
      if (m[i]) begin
        if (exp_n < DEP) begin
          exp_q[exp_n] = {1'b0, 8'(ts), 2'(i / NL), half_sel[i / NL], 4'(i % NL)};
          exp_n++;
        end else begin
          exp_ovf = 1;
        end
      end
    end
    disc = disc | m;
    repeat (hold) @(negedge clk);
    disc = disc & ~m;
    repeat (8) @(negedge clk);
    check(!out_valid, "R7 no stream while collecting", 32'(out_valid), 32'd0);
  endtask

  task automatic drain(input string tag);
    bit          done;
    int          got;
    int          guard;
    int          ph;
    bit          hold;
    logic [15:0] held;
    done = 0; got = 0; guard = 0; ph = 0; hold = 0; held = '0;
    spill_win = 1'b0;
    late_win  = 1'b0;
    while (!done && guard < 400) begin
      @(negedge clk);
      guard++;
      if (hold) check(out_valid && out_data == held, "R10 word held under stall", 32'(out_data), 32'(held));
      hold = 0;
      if (out_valid) begin
        out_ready = ((ph % 3) != 2);
        ph++;
        if (out_ready) begin
          if (got < exp_n) begin
            check(out_data == exp_q[got], {tag, " hit word"}, 32'(out_data), 32'(exp_q[got]));
            got++;
          end else begin
            check(out_data == {1'b1, exp_ovf, 10'b0, 4'(exp_n)}, "R9 trailer word",
                  32'(out_data), 32'({1'b1, exp_ovf, 10'b0, 4'(exp_n)}));
            done = 1;
          end
        end else begin
          hold = 1;
          held = out_data;
        end
      end else begin
        out_ready = 1'b0;
      end
    end
    if (!done) check(0, "R7 stream did not complete", 32'(got), 32'(exp_n));
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid, "R11 idle after reset", 32'(out_valid), 32'd0);

    // R5: an edge with both windows closed must never reach the stream.
    disc[5] = 1'b1;
    repeat (2) @(negedge clk);
    disc[5] = 1'b0;
    repeat (8) @(negedge clk);
    check(!out_valid, "R5 closed-window edge ignored", 32'(out_valid), 32'd0);

    // Sweep every line once, varying the half pattern; odd spills hand over to the late window.
    for (int sp = 0; sp < 8; sp++) begin
      begin_spill(NC'(sp * 5 + 3));
      for (int j = 0; j < 8; j++) begin
        if ((sp % 2) == 1 && j == 4) begin
          spill_win = 1'b0;
          late_win  = 1'b1;
        end
        fire(NLINE'(1) << (sp * 8 + j), 2);
      end
      drain("R1/R2/R4/R5");
    end

    // R6: simultaneous hits across chips, then a second group.
    begin_spill(4'b1010);
    fire((NLINE'(1) << 63) | (NLINE'(1) << 0) | (NLINE'(1) << 17) |
         (NLINE'(1) << 40) | (NLINE'(1) << 33), 2);
    fire((NLINE'(1) << 3) | (NLINE'(1) << 2), 1);
    drain("R6");

    // R1: a long high level is one hit; a fresh rise is another.
    begin_spill(4'b0000);
    fire(NLINE'(1) << 20, 20);
    fire(NLINE'(1) << 20, 2);
    drain("R1");

    // R3: a hit before and after the counter limit.
    begin_spill(4'b1111);
    repeat (240) @(negedge clk);
    fire(NLINE'(1) << 7, 2);
    repeat (40) @(negedge clk);
    fire(NLINE'(1) << 50, 2);
    drain("R2/R3");

    // R8: more hits than the buffer holds.
    begin_spill(4'b0110);
    for (int k = 0; k < 11; k++) fire(NLINE'(1) << (k * 5), 2);
    drain("R8");

    // R9: flag and count restart on the next spill, and for an empty one.
    begin_spill(4'b0101);
    fire(NLINE'(1) << 60, 2);
    drain("R9");
    begin_spill(4'b0000);
    repeat (4) @(negedge clk);
    drain("R9 empty spill");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL R7 watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule